// File: doc/BRIEF.md
# Serial Pin Expander

This block carries a wide parallel pin bank to the outside of the chip over three output wires and one input wire. Off-chip shift registers are chained to it. The block repeats one frame after another. In each frame it drives a programmable number of latched output bits onto the serial data line. In the same frame it collects the same number of bits from the serial input line.

Each frame starts with one serial-clock period during which the load strobe is low. The external input registers capture their parallel pins in this period. The data clocks follow, with output bit 0 first and input bit 0 first. Input bits gather in a hidden shift register. They are copied into the readable snapshot in a single step when the frame ends, so software never sees a half-shifted word. A change to the output latch or to the configuration waits for the next frame boundary.

Software reaches the block through plain write and read strobes. The control word is at address 0. The output latch words follow it, and the input snapshot words come after those. Bit j of the chain is stored in word j/32, at bit position j%32.

Top module: `serial_pin_expander`

## Requirements
- R1: While the enable bit is clear, the serial clock and the load strobe rest high and the serial data output rests low.
- R2: When enabled, the serial clock repeats every 2×(D+1) clock cycles, where D is the effective divider. It is low for the first half and high for the second half.
- R3: A programmed divider of 0 acts as 1. Any other value up to 65535 is used unchanged.
- R4: The effective pin-byte count is the programmed 4-bit count, raised to 1 when it is 0 and lowered to 10 when it is above 10. Each frame has exactly 8× that count data clocks.
- R5: Each frame starts with exactly one serial-clock period of load strobe low. The load strobe stays high during all data clocks.
- R6: Output latch bit k appears on the serial data line during data clock k (k from 0) and is stable at its rising edge.
- R7: The serial input is sampled on each rising edge of a data clock, and data clock k fills snapshot bit k. Snapshot bits at and above 8× the effective count read as 0.
- R8: The input snapshot changes only at a frame boundary, and all its bits change together.
- R9: A write to the output latch during a frame does not change the bits shifted in that frame. The new value is shifted in the next frame.
- R10: Control word at address 0 (bit 0 enable, bits 9:6 pin-byte count, bits 31:16 divider). When read back, the divider field shows the written divider shifted left by one bit, and all other bits read 0. Output latch words sit at addresses 1 to 3 and read back as written. Input snapshot words sit at addresses 4 to 6. Bit j of the chain maps to word j/32, bit j%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ser_clk | output | 1 | Divided serial clock |
| ser_load | output | 1 | Load strobe, active low |
| ser_dout | output | 1 | Serial data to the external chain |
| ser_din | input | 1 | Serial data from the external chain |
| par_out | output | 80 | Output latch contents |
| par_in | output | 80 | Input snapshot contents |

## Verification
The embedded properties check several rules on every cycle. The lines rest idle after enable drops. The serial clock phase only turns over at a divider terminal count. The slot index stays inside the frame length. The transmit word and the snapshot stay untouched between frame boundaries. The effective divider and byte count stay within their legal ranges. Some behaviour only the bench scenarios can show: the actual bit order on the wire, the lengths of the period, the load window and the frame for each divider and count, the clamping of illegal counts, the divider readback shift, and that a mid-frame latch write appears one frame later.

// File: rtl/spx_pkg.sv
package spx_pkg;

   localparam int DIV_W       = 16;
   localparam int NB_W        = 4;
   localparam int CTRL_EN     = 0;
   localparam int CTRL_NB_LO  = 6;
   localparam int CTRL_DIV_LO = 16;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic [NB_W-1:0]  nbytes;
      logic             en;
   } spx_cfg_t;

   // divider floor: zero is not a legal period
   function automatic logic [DIV_W-1:0] div_floor(input logic [DIV_W-1:0] d);
      return (d == '0) ? DIV_W'(1) : d;
   endfunction

   // byte count clamp into 1..maxb
   function automatic logic [NB_W-1:0] nb_clamp(input logic [NB_W-1:0] n,
                                                input int unsigned maxb);
      if (n == '0) return NB_W'(1);
      if (32'(n) > maxb) return NB_W'(maxb);
      return n;
   endfunction

endpackage

// File: rtl/spx_regs.sv
module spx_regs
   import spx_pkg::*;
#(
   parameter int MAX_BYTES = 10,
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [BUS_W-1:0]       wdata,
   input  logic [8*MAX_BYTES-1:0] snap,
   output logic [BUS_W-1:0]       rdata,
   output spx_cfg_t               cfg,
   output logic [8*MAX_BYTES-1:0] olat
);
   localparam int CHAIN_W = 8 * MAX_BYTES;
   localparam int NW      = (CHAIN_W + BUS_W - 1) / BUS_W;
   localparam int PAD_W   = NW * BUS_W;

   spx_cfg_t           cfg_q;
   logic [CHAIN_W-1:0] olat_q;
   logic [PAD_W-1:0]   merge_pad_unused;
   logic [PAD_W-1:0]   olat_pad;
   logic [PAD_W-1:0]   snap_pad;
   logic               wdata_unused;

   assign wdata_unused = ^{wdata[CTRL_DIV_LO-1:CTRL_NB_LO+NB_W], wdata[CTRL_NB_LO-1:CTRL_EN+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we && addr == '0) begin
         cfg_q.div    <= wdata[CTRL_DIV_LO +: DIV_W];
         cfg_q.nbytes <= wdata[CTRL_NB_LO +: NB_W];
         cfg_q.en     <= wdata[CTRL_EN];
      end
   end

   always_comb begin
      merge_pad_unused = PAD_W'(olat_q);
      for (int w = 0; w < NW; w++) begin
         if (we && addr == ADDR_W'(1 + w))
            merge_pad_unused[w*BUS_W +: BUS_W] = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) olat_q <= '0;
      else        olat_q <= merge_pad_unused[CHAIN_W-1:0];
   end

   assign olat_pad = PAD_W'(olat_q);
   assign snap_pad = PAD_W'(snap);

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata = {cfg_q.div[DIV_W-2:0], 1'b0, 6'b0, cfg_q.nbytes, 5'b0, cfg_q.en};
      for (int w = 0; w < NW; w++) begin
         if (addr == ADDR_W'(1 + w))      rdata = olat_pad[w*BUS_W +: BUS_W];
         if (addr == ADDR_W'(1 + NW + w)) rdata = snap_pad[w*BUS_W +: BUS_W];
      end
   end

   assign cfg  = cfg_q;
   assign olat = olat_q;

endmodule

// File: rtl/spx_clkdiv.sv
module spx_clkdiv #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] lim,
   output logic             tick,
   output logic             phase
);
   logic [DIV_W-1:0] cnt_q;
   logic             phase_q;

   assign tick  = run && (cnt_q == lim);
   assign phase = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!run) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (tick) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R2
   half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> $stable(phase_q));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim);

endmodule

// File: rtl/spx_frame.sv
module spx_frame
   import spx_pkg::*;
#(
   parameter int MAX_BYTES = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [DIV_W-1:0]       div_eff,
   input  logic [NB_W-1:0]        nb_eff,
   input  logic [8*MAX_BYTES-1:0] olat,
   input  logic                   tick,
   input  logic                   phase,
   input  logic                   ser_din,
   output logic                   run,
   output logic [DIV_W-1:0]       lim,
   output logic                   ser_clk,
   output logic                   ser_load,
   output logic                   ser_dout,
   output logic [8*MAX_BYTES-1:0] snap
);
   localparam int CHAIN_W = 8 * MAX_BYTES;
   localparam int SLOT_W  = $clog2(CHAIN_W + 1);

   logic               run_q;
   logic [DIV_W-1:0]   lim_q;
   logic [NB_W-1:0]    nb_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [SLOT_W-1:0]  last_slot;
   logic [CHAIN_W-1:0] tx_q, rx_q, snap_q, keep;
   logic               fall, rise, wrap;

   assign fall      = tick && phase;
   assign rise      = tick && !phase;
   assign last_slot = SLOT_W'({nb_q, 3'b000});
   assign wrap      = (slot_q == last_slot);

   always_comb begin
      for (int i = 0; i < CHAIN_W; i++)
         keep[i] = (SLOT_W'(i) < last_slot);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         lim_q  <= DIV_W'(1);
         nb_q   <= NB_W'(1);
         slot_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         snap_q <= '0;
      end else begin
         run_q <= en;
         if (!run_q || (fall && wrap)) begin
            lim_q <= div_eff;
            nb_q  <= nb_eff;
            tx_q  <= olat;
         end else if (fall && slot_q != '0) begin
            tx_q  <= tx_q >> 1;
         end
         if (!run_q)    slot_q <= '0;
         else if (fall) slot_q <= wrap ? '0 : slot_q + 1'b1;
         for (int i = 0; i < CHAIN_W; i++) begin
            if (rise && slot_q == SLOT_W'(i + 1)) rx_q[i] <= ser_din;
         end
         if (fall && wrap) snap_q <= rx_q & keep;
      end
   end

   assign run      = run_q;
   assign lim      = lim_q;
   assign ser_clk  = run_q ? phase : 1'b1;
   assign ser_load = run_q ? (slot_q != '0) : 1'b1;
   assign ser_dout = (run_q && slot_q != '0) ? tx_q[0] : 1'b0;
   assign snap     = snap_q;

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ser_clk && ser_load && !ser_dout);

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && !fall |=> $stable(tx_q));

   // R8
   snap_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall && wrap) |=> $stable(snap_q));

   // R5
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && $fell(ser_load) |-> $past(fall && wrap) || !$past(run_q));

   // R4
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= last_slot && nb_q != '0 && 32'(nb_q) <= MAX_BYTES);

   // R3
   lim_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lim_q != '0);

endmodule

// File: rtl/serial_pin_expander.sv
module serial_pin_expander
   import spx_pkg::*;
#(
   parameter int MAX_BYTES = 10,
   parameter int BUS_W     = 32,
   localparam int CHAIN_W  = 8 * MAX_BYTES,
   localparam int NW       = (CHAIN_W + BUS_W - 1) / BUS_W,
   localparam int ADDR_W   = $clog2(1 + 2 * NW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [BUS_W-1:0]   reg_wdata,
   output logic [BUS_W-1:0]   reg_rdata,
   output logic               ser_clk,
   output logic               ser_load,
   output logic               ser_dout,
   input  logic               ser_din,
   output logic [CHAIN_W-1:0] par_out,
   output logic [CHAIN_W-1:0] par_in
);
   generate
      if (MAX_BYTES < 1 || MAX_BYTES > (1 << NB_W) - 1) begin : g_bad_bytes
         $error("MAX_BYTES must fit the 4-bit count field");
      end
      if (BUS_W != 32) begin : g_bad_bus
         $error("control field layout needs a 32-bit bus");
      end
   endgenerate

   spx_cfg_t           cfg;
   logic [CHAIN_W-1:0] olat, snap;
   logic               run, tick, phase;
   logic [DIV_W-1:0]   lim;

   spx_regs #(.MAX_BYTES(MAX_BYTES), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .snap(snap), .rdata(reg_rdata), .cfg(cfg), .olat(olat)
   );

   spx_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
      .clk(clk), .rst_n(rst_n), .run(run), .lim(lim), .tick(tick), .phase(phase)
   );

   spx_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(cfg.en),
      .div_eff(div_floor(cfg.div)), .nb_eff(nb_clamp(cfg.nbytes, MAX_BYTES)),
      .olat(olat), .tick(tick), .phase(phase), .ser_din(ser_din),
      .run(run), .lim(lim), .ser_clk(ser_clk), .ser_load(ser_load),
      .ser_dout(ser_dout), .snap(snap)
   );

   assign par_out = olat;
   assign par_in  = snap;

endmodule

// File: tb/tb_serial_pin_expander.sv
module tb_serial_pin_expander;
   localparam int CW = 80;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          we = 1'b0;
   logic [2:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          sclk, sload, sdout;
   logic          sdin = 1'b0;
   logic [CW-1:0] pout, pin;

   serial_pin_expander dut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .ser_clk(sclk), .ser_load(sload), .ser_dout(sdout),
      .ser_din(sdin), .par_out(pout), .par_in(pin)
   );

   int vec = 0, bad = 0;
   logic [CW-1:0] in_pat = '0, cap = '0, last_frame = '0;
   int bitn = 0, last_len = 0, frames = 0, cyc = 0, last_rise = -1;
   int period = 0, load_len = 0, lowrun = 0, dslot = 0;
   logic psclk = 1'b1, psload = 1'b1;

   // external chain model, sampled on the falling clock edge
   initial forever begin
      @(negedge clk);
      cyc++;
      if (sclk && !psclk) begin
         if (last_rise >= 0) period = cyc - last_rise;
         last_rise = cyc;
         if (!sload) begin
            if (bitn > 0) begin last_len = bitn; last_frame = cap; frames++; end
            bitn = 0;
         end else begin
            if (bitn < CW) cap[bitn] = sdout;
            bitn++;
         end
      end
      if (!sclk && psclk) begin
         if (sload) begin sdin = (dslot < CW) ? in_pat[dslot] : 1'b0; dslot++; end
         else begin dslot = 0; sdin = 1'b0; end
      end
      if (!sload) lowrun++;
      else if (!psload) begin load_len = lowrun; lowrun = 0; end
      psclk = sclk;
      psload = sload;
   end

   task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      addr = a;
      #2 d = rdata;
   endtask

   task automatic set_latch(input logic [CW-1:0] v);
      wr(3'd1, v[31:0]);
      wr(3'd2, v[63:32]);
      wr(3'd3, {16'h0, v[79:64]});
   endtask

   task automatic read_snap(output logic [CW-1:0] v);
      logic [31:0] w0, w1, w2;
      rd(3'd4, w0); rd(3'd5, w1); rd(3'd6, w2);
      v = {w2[15:0], w1, w0};
   endtask

   task automatic wait_frames(input int n);
      int t;
      t = frames + n;
      while (frames < t) @(posedge clk);
      #1;
   endtask

   function automatic logic [CW-1:0] mask_of(input int nbe);
      logic [CW-1:0] m;
      m = '0;
      for (int i = 0; i < CW; i++) if (i < 8 * nbe) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] ctrl_word(input logic [15:0] d, input logic [3:0] n, input logic e);
      return {d, 6'b0, n, 5'b0, e};
   endfunction

   task automatic sweep_point(input int divw, input int nbw);
      int dive, nbe;
      logic [CW-1:0] olat, m, snap;
      dive = (divw == 0) ? 1 : divw;
      nbe  = (nbw == 0) ? 1 : ((nbw > 10) ? 10 : nbw);
      m    = mask_of(nbe);
      olat   = {$urandom(), $urandom(), $urandom()};
      in_pat = {$urandom(), $urandom(), $urandom()};
      set_latch(olat);
      bitn = 0; frames = 0; last_rise = -1; lowrun = 0;
      wr(3'd0, ctrl_word(16'(divw), 4'(nbw), 1'b1));
      wait_frames(2);
      // R4 frame length after clamping
      check("R4 frame length", CW'(last_len), CW'(8 * nbe));
      // R2 R3 serial clock period with divider floor
      check("R2/R3 sclk period", CW'(period), CW'(2 * (dive + 1)));
      // R5 load window is one serial period
      check("R5 load window", CW'(load_len), CW'(2 * (dive + 1)));
      // R6 output bit order
      check("R6 shifted output", last_frame & m, olat & m);
      read_snap(snap);
      // R7 input capture order and zeroed upper bits
      check("R7 input snapshot", snap, in_pat & m);
      wr(3'd0, 32'h0);
      repeat (3) @(posedge clk);
      #1;
      // R1 idle after disable
      check("R1 idle lines", CW'({sclk, sload, sdout}), CW'(3'b110));
      bitn = 0;
   endtask

   initial begin
      logic [31:0] r;
      logic [CW-1:0] x, y, a, b, m;
      int odd;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state of the lines
      check("R1 reset lines", CW'({sclk, sload, sdout}), CW'(3'b110));
      rd(3'd0, r);
      // R10 control reads zero after reset
      check("R10 reset ctrl", CW'(r), '0);

      // R10 divider readback shift, fields, top divider bit lost
      wr(3'd0, ctrl_word(16'h8003, 4'd5, 1'b0));
      rd(3'd0, r);
      check("R10 ctrl readback", CW'(r), CW'(ctrl_word(16'h0006, 4'd5, 1'b0)));
      x = {16'hBEEF, 32'h1234_5678, 32'h9ABC_DEF0};
      set_latch(x);
      rd(3'd2, r);
      // R10 output word mapping
      check("R10 latch word 1", CW'(r), CW'(32'h1234_5678));
      rd(3'd3, r);
      check("R10 latch word 2", CW'(r), CW'(32'h0000_BEEF));
      check("R10 par_out", pout, x);
      wr(3'd0, 32'h0);

      foreach (x[i]) ; // no-op
      for (int d = 0; d < 4; d++) begin
         for (int k = 0; k < 5; k++) begin
            int nbs [5] = '{0, 1, 3, 10, 13};
            sweep_point((d == 3) ? 4 : d, nbs[k]);
         end
      end

      // R8 R9 mid-frame behaviour, divider 1, two bytes
      m = mask_of(2);
      x = 80'h0000_0000_0000_0000_C35A;
      y = 80'h0000_0000_0000_0000_0FF1;
      a = 80'h0000_0000_0000_0000_6B2D;
      b = 80'h0000_0000_0000_0000_9172;
      set_latch(x);
      in_pat = a;
      bitn = 0; frames = 0; last_rise = -1; lowrun = 0;
      wr(3'd0, ctrl_word(16'd1, 4'd2, 1'b1));
      wait_frames(2);
      @(negedge sload);
      in_pat = b;
      odd = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (pin !== (a & m)) odd++;
      end
      set_latch(y);
      @(negedge clk);
      while (sload) begin
         if (pin !== (a & m)) odd++;
         @(negedge clk);
      end
      // R8 snapshot never partial during the frame
      check("R8 snapshot held in frame", CW'(odd), '0);
      // R8 snapshot replaced as a whole at the boundary
      check("R8 snapshot at boundary", pin, b & m);
      wait_frames(1);
      // R9 frame in progress kept old latch value
      check("R9 frame kept old latch", last_frame & m, x & m);
      wait_frames(1);
      // R9 new latch value in the following frame
      check("R9 next frame new latch", last_frame & m, y & m);
      wr(3'd0, 32'h0);
      repeat (3) @(posedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vec++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule